// File: doc/BRIEF.md
# Pixel Write Command Packer

This block sits between a serial byte receiver and the write FIFO of a frame-buffer memory path. The receiver reports each byte with a one-cycle strobe. The packer collects the bytes in groups of five and turns each group into one 40-bit write command. The first three bytes of a group form a pixel address. The last two bytes form an RGB565 pixel value. When a group is complete, the command is pushed into the downstream FIFO with a single-cycle write enable.

No marker in the byte stream shows where a group starts. Alignment is set only by reset, so a byte that goes missing shifts every later command. The packer also sends a hold request back toward the sender whenever the FIFO reports that it is nearly full or full. If the FIFO is already full when a group completes, the command is discarded and a sticky overflow flag is raised.

Top module: `pix_cmd_packer`

## Requirements
- R1: After reset, `fifo_we` and `overflow` are 0 and the byte count is zero, so the next five strobed bytes form one complete, aligned command.
- R2: A byte is taken only in a cycle where `rx_stb` is 1. Changes on `rx_data` while `rx_stb` is 0 have no effect on any command word.
- R3: On the clock edge that takes the fifth byte of a group, when `fifo_full` is 0, `fifo_we` goes high on that same edge and stays high for exactly one cycle.
- R4: Command layout: `fifo_wdata[39:16]` is the address, where the first byte received is bits 39:32. `fifo_wdata[15:0]` is the pixel, where the fourth byte is bits 15:8 and the fifth byte is bits 7:0.
- R5: After the fifth byte, the count goes back to zero, so the next byte starts a new group. This holds for strobes in consecutive cycles and for strobes separated by idle cycles.
- R6: If `fifo_full` is 1 in the cycle the fifth byte is strobed, no write takes place and `overflow` goes to 1. `overflow` then stays at 1 until reset, and later groups are still written normally.
- R7: `sender_hold` is 1 in any cycle where `fifo_afull` or `fifo_full` is 1, and 0 otherwise, with no register delay.
- R8: A reset in the middle of a group discards the partial group, and the following five bytes form a correctly aligned command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Byte from the receiver |
| rx_stb | input | 1 | One-cycle strobe that marks a valid byte |
| fifo_full | input | 1 | Downstream FIFO full |
| fifo_afull | input | 1 | Downstream FIFO nearly full |
| fifo_we | output | 1 | Write enable into the FIFO, one cycle per command |
| fifo_wdata | output | 40 | Command word: address in bits 39:16, pixel in bits 15:0 |
| sender_hold | output | 1 | Hold request sent back toward the sender |
| overflow | output | 1 | Sticky flag: a command was dropped because the FIFO was full |

## Verification
The hardest case to reach from the ports is a dropped command. It needs `fifo_full` high in exactly the cycle of the fifth strobe, followed by proof that the group boundary still moved on and that the next command is intact. The bench raises `fifo_full` only alongside that fifth byte. It then sends a fresh group with `fifo_full` low and checks its word and the sticky flag. Misalignment recovery is reached by resetting after two bytes of a group, then checking that the next five bytes produce one clean word.

// File: rtl/pix_cmd_packer.sv
module pix_cmd_packer #(
  parameter int ADDR_BYTES = 3,
  parameter int PIX_BYTES  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [7:0]                        rx_data,
  input  logic                              rx_stb,
  input  logic                              fifo_full,
  input  logic                              fifo_afull,
  output logic                              fifo_we,
  output logic [8*(ADDR_BYTES+PIX_BYTES)-1:0] fifo_wdata,
  output logic                              sender_hold,
  output logic                              overflow
);
  localparam int NB = ADDR_BYTES + PIX_BYTES;
  localparam int W  = 8 * NB;
  localparam int CW = $clog2(NB);

  logic [CW-1:0] cnt;
  logic [W-9:0]  acc;
  logic          last;

  assign last        = rx_stb && (cnt == CW'(NB-1));
  assign sender_hold = fifo_afull | fifo_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      acc        <= '0;
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
      overflow   <= 1'b0;
    end else begin
      fifo_we <= 1'b0;
      if (rx_stb) begin
        acc <= {acc[W-17:0], rx_data};
        cnt <= last ? '0 : cnt + 1'b1;
      end
      if (last) begin
        if (fifo_full) overflow <= 1'b1;
        else begin
          fifo_we    <= 1'b1;
          fifo_wdata <= {acc, rx_data};
        end
      end
    end
  end

  AST_WRITE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !fifo_full) |=> fifo_we); // R3
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |=> !fifo_we); // R3
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (last && fifo_full) |=> (!fifo_we && overflow)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R6
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_stb |=> $stable(cnt)); // R2
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(NB)); // R5
endmodule

// File: tb/pix_cmd_packer_tb.sv
module pix_cmd_packer_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_stb = 0;
  logic        fifo_full = 0;
  logic        fifo_afull = 0;
  logic        fifo_we;
  logic [39:0] fifo_wdata;
  logic        sender_hold;
  logic        overflow;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pix_cmd_packer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_stb(rx_stb),
    .fifo_full(fifo_full), .fifo_afull(fifo_afull), .fifo_we(fifo_we),
    .fifo_wdata(fifo_wdata), .sender_hold(sender_hold), .overflow(overflow)
  );

  // {command word, idle gap between bytes}
  localparam logic [47:0] VEC [6] = '{
    {40'h04AFFF_F81F, 8'd0},
    {40'h000000_0000, 8'd1},
    {40'h04AFFE_FFFF, 8'd3},
    {40'h123456_789A, 8'd0},
    {40'hFFFFFF_07E0, 8'd2},
    {40'h010203_0405, 8'd0}
  };

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap, input bit full_on_it);
    @(negedge clk);
    rx_data = b; rx_stb = 1; fifo_full = full_on_it;
    @(negedge clk);
    rx_stb = 0; fifo_full = 0;
    for (int g = 0; g < gap; g++) begin
      rx_data = ~b ^ 8'(g);
      @(negedge clk);
    end
  endtask

  task automatic send_pkt(input logic [39:0] w, input int gap);
    for (int i = 0; i < 5; i++) send_byte(w[39-8*i -: 8], (i == 4) ? 0 : gap, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fifo_we == 0 && overflow == 0, "R1 reset outputs", {38'd0, fifo_we, overflow}, 40'd0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      send_pkt(VEC[v][47:8], int'(VEC[v][7:0]));
      check(fifo_we == 1, "R3 write after fifth byte", {39'd0, fifo_we}, 40'd1);
      check(fifo_wdata == VEC[v][47:8], "R4/R2/R5 word layout", fifo_wdata, VEC[v][47:8]);
      @(negedge clk);
      check(fifo_we == 0, "R3 single-cycle write", {39'd0, fifo_we}, 40'd0);
    end

    // R2: strobe-less activity produces no write
    for (int i = 0; i < 8; i++) begin
      rx_data = 8'(i * 37); @(negedge clk);
      check(fifo_we == 0, "R2 no write without strobe", {39'd0, fifo_we}, 40'd0);
    end

    // R7: hold request
    fifo_afull = 1; #1;
    check(sender_hold == 1, "R7 hold on afull", {39'd0, sender_hold}, 40'd1);
    fifo_afull = 0; fifo_full = 1; #1;
    check(sender_hold == 1, "R7 hold on full", {39'd0, sender_hold}, 40'd1);
    fifo_full = 0; #1;
    check(sender_hold == 0, "R7 hold released", {39'd0, sender_hold}, 40'd0);

    // R6: full at completion drops the word
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i), 0, 1'b0);
    send_byte(8'hA4, 0, 1'b1);
    check(fifo_we == 0, "R6 dropped write", {39'd0, fifo_we}, 40'd0);
    check(overflow == 1, "R6 overflow set", {39'd0, overflow}, 40'd1);
    send_pkt(40'h0BEEF0_1234, 1);
    check(fifo_we == 1 && fifo_wdata == 40'h0BEEF0_1234, "R6 next group written", fifo_wdata, 40'h0BEEF0_1234);
    check(overflow == 1, "R6 overflow sticky", {39'd0, overflow}, 40'd1);

    // R8: reset mid-group realigns
    send_byte(8'h55, 0, 1'b0);
    send_byte(8'h66, 0, 1'b0);
    rst_n = 0; @(negedge clk);
    check(overflow == 0 && fifo_we == 0, "R1 reset clears overflow", {38'd0, fifo_we, overflow}, 40'd0);
    rst_n = 1; @(negedge clk);
    send_pkt(40'h00C0DE_ABCD, 0);
    check(fifo_we == 1 && fifo_wdata == 40'h00C0DE_ABCD, "R8 realigned after reset", fifo_wdata, 40'h00C0DE_ABCD);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule